// File: doc/BRIEF.md
# Execute-in-Place Fetch Translator

This block turns 32-bit memory-mapped reads into serial-flash read transactions. The upper four address bits choose a 256 MB window. A read that falls inside the window while translation is enabled becomes one frame for a separate SPI transfer engine. The frame holds the programmed read opcode, then 1 to 4 address bytes, then room for four data bytes. When the engine reports completion, the four bytes it received are packed into a word and returned on the read bus.

The requester uses a level request with a one-cycle acknowledge. The translator handles one fetch at a time. While translation is enabled it has sole control of the engine, and it waits for the engine's busy flag to clear before it launches a frame. Reads outside the window, writes to the window, and any access made while translation is off are acknowledged with an error flag and produce no serial traffic.

Top module: `xip_fetch_bridge`

## Requirements
- R1: After reset, `bus_ack_o`, `bus_err_o` and `spi_start_o` are low and `bus_rdata_o` is zero.
- R2: A read whose address bits 31:28 equal `cfg_page_i` launches exactly one engine transaction and is acknowledged without error.
- R3: Translation happens only when both `cfg_module_en_i` and `cfg_xip_en_i` are 1. If either one is 0, any request gets an error acknowledge and no launch.
- R4: A read outside the window is acknowledged with `bus_err_o`=1 in the cycle after it is accepted. It launches nothing, and `bus_rdata_o` is zero.
- R5: A write (`bus_we_i`=1) inside the window gets an error acknowledge and launches nothing.
- R6: The first frame byte is the read opcode, placed in `spi_txdata_o[63:56]`.
- R7: `cfg_abytes_m1_i` values 0 to 3 select 1 to 4 address bytes. These are the low bytes of `{4'h0, addr[27:0]}`, sent most significant first in the bytes after the opcode. All later frame bits are zero.
- R8: `spi_nbytes_o` equals the address-byte count plus 5 (6 to 9).
- R9: `spi_rxdata_i` holds the four received bytes with the first one in bits 31:24. The returned word puts the first received byte in bits 7:0 and the last in bits 31:24.
- R10: A frame is launched in the cycle after the translator sees `spi_busy_i` low while it waits. With no wait that is two cycles after the request is accepted. At most one fetch is outstanding.
- R11: `bus_ack_o` is a single-cycle pulse that comes one cycle after `spi_done_i` is sampled. `bus_err_o` is only ever high together with `bus_ack_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_module_en_i | input | 1 | Module enable |
| cfg_xip_en_i | input | 1 | Translation enable |
| cfg_page_i | input | 4 | Window select, compared with address bits 31:28 |
| cfg_abytes_m1_i | input | 2 | Address byte count minus one |
| cfg_rd_cmd_i | input | 8 | Flash read opcode |
| bus_req_i | input | 1 | Request, held until acknowledged |
| bus_we_i | input | 1 | Write flag of the request |
| bus_addr_i | input | 32 | Request address |
| bus_ack_o | output | 1 | One-cycle acknowledge |
| bus_err_o | output | 1 | Error flag, valid with acknowledge |
| bus_rdata_o | output | 32 | Returned word |
| spi_start_o | output | 1 | One-cycle launch pulse to the engine |
| spi_nbytes_o | output | 4 | Total bytes of the frame |
| spi_txdata_o | output | 64 | Frame bytes, first byte in the top bits |
| spi_busy_i | input | 1 | Engine busy |
| spi_done_i | input | 1 | Engine completion pulse |
| spi_rxdata_i | input | 32 | Last four received bytes, first in bits 31:24 |

## Verification
Assertions check every cycle that the acknowledge is a pulse, that the error flag appears only with an acknowledge and never with a launch, that launches never come back to back, and that each launched frame starts with the opcode and has a length between 6 and 9 bytes. Other behaviours depend on particular stimulus sequences, so only the bench scenarios can show them. These are the exact address-byte placement for each count, the byte reversal of the returned word, and the cycle timing of launch and acknowledge, both directly and after a long busy period. They also include the refusals for window misses, writes and disabled translation, with a launch counter confirming that no serial traffic happened.

// File: rtl/xip_pkg.sv
package xip_pkg;
    localparam int XIP_ADDR_W = 32;
    localparam int XIP_DATA_W = 32;
    localparam int XIP_TX_W   = 64;
    localparam int XIP_NB_W   = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_XFER = 2'd2
    } xip_state_e;

    typedef struct packed {
        xip_state_e              state;
        logic [XIP_ADDR_W-1:0]   addr;
        logic                    ack;
        logic                    err;
        logic [XIP_DATA_W-1:0]   rdata;
        logic                    start;
        logic [XIP_TX_W-1:0]     tx;
        logic [XIP_NB_W-1:0]     nbytes;
    } xip_regs_t;
endpackage

// File: rtl/xip_window_decode.sv
module xip_window_decode #(
    parameter int ADDR_W = 32,
    parameter int PAGE_W = 4
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [PAGE_W-1:0] page_i,
    input  logic              module_en_i,
    input  logic              xip_en_i,
    input  logic              we_i,
    output logic              take_o
);
    logic in_window;
    assign in_window = (addr_i[ADDR_W-1 -: PAGE_W] == page_i);
    assign take_o    = module_en_i & xip_en_i & ~we_i & in_window;
endmodule

// File: rtl/xip_frame_builder.sv
module xip_frame_builder #(
    parameter int ADDR_W = 32,
    parameter int PAGE_W = 4,
    parameter int TX_W   = 64,
    parameter int NB_W   = 4
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        cmd_i,
    input  logic [1:0]        abytes_m1_i,
    output logic [TX_W-1:0]   tx_o,
    output logic [NB_W-1:0]   nbytes_o
);
    localparam int MAX_AB   = 4;
    localparam int DATA_BYT = 4;
    localparam int TAIL_W   = TX_W - 8 - 8 * MAX_AB;

    logic [8*MAX_AB-1:0] win_addr;
    assign win_addr = {PAGE_W'(0), addr_i[ADDR_W-PAGE_W-1:0]};

    assign tx_o[TX_W-1 -: 8] = cmd_i;

    for (genvar g = 0; g < MAX_AB; g++) begin : g_slot
        assign tx_o[TX_W-9-8*g -: 8] = (2'(g) <= abytes_m1_i)
            ? win_addr[{abytes_m1_i - 2'(g), 3'b000} +: 8]
            : 8'h00;
    end

    assign tx_o[TAIL_W-1:0] = '0;
    assign nbytes_o = NB_W'(abytes_m1_i) + NB_W'(1 + 1 + DATA_BYT);
endmodule

// File: rtl/xip_rx_swap.sv
module xip_rx_swap #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] rx_i,
    output logic [DATA_W-1:0] word_o
);
    localparam int NBYTE = DATA_W / 8;
    for (genvar g = 0; g < NBYTE; g++) begin : g_byte
        assign word_o[8*g +: 8] = rx_i[DATA_W-8-8*g +: 8];
    end
endmodule

// File: rtl/xip_fetch_bridge.sv
module xip_fetch_bridge
    import xip_pkg::*;
#(
    parameter int PAGE_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_module_en_i,
    input  logic                  cfg_xip_en_i,
    input  logic [PAGE_W-1:0]     cfg_page_i,
    input  logic [1:0]            cfg_abytes_m1_i,
    input  logic [7:0]            cfg_rd_cmd_i,
    input  logic                  bus_req_i,
    input  logic                  bus_we_i,
    input  logic [XIP_ADDR_W-1:0] bus_addr_i,
    output logic                  bus_ack_o,
    output logic                  bus_err_o,
    output logic [XIP_DATA_W-1:0] bus_rdata_o,
    output logic                  spi_start_o,
    output logic [XIP_NB_W-1:0]   spi_nbytes_o,
    output logic [XIP_TX_W-1:0]   spi_txdata_o,
    input  logic                  spi_busy_i,
    input  logic                  spi_done_i,
    input  logic [XIP_DATA_W-1:0] spi_rxdata_i
);
    xip_regs_t r_q, r_d;

    logic                  take_req;
    logic [XIP_TX_W-1:0]   frame_tx;
    logic [XIP_NB_W-1:0]   frame_nb;
    logic [XIP_DATA_W-1:0] rx_word;

    xip_window_decode #(.ADDR_W(XIP_ADDR_W), .PAGE_W(PAGE_W)) u_decode (
        .addr_i      (bus_addr_i),
        .page_i      (cfg_page_i),
        .module_en_i (cfg_module_en_i),
        .xip_en_i    (cfg_xip_en_i),
        .we_i        (bus_we_i),
        .take_o      (take_req)
    );

    xip_frame_builder #(.ADDR_W(XIP_ADDR_W), .PAGE_W(PAGE_W),
                        .TX_W(XIP_TX_W), .NB_W(XIP_NB_W)) u_frame (
        .addr_i      (r_q.addr),
        .cmd_i       (cfg_rd_cmd_i),
        .abytes_m1_i (cfg_abytes_m1_i),
        .tx_o        (frame_tx),
        .nbytes_o    (frame_nb)
    );

    xip_rx_swap #(.DATA_W(XIP_DATA_W)) u_swap (
        .rx_i   (spi_rxdata_i),
        .word_o (rx_word)
    );

    always_comb begin
        r_d       = r_q;
        r_d.ack   = 1'b0;
        r_d.err   = 1'b0;
        r_d.start = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                if (bus_req_i && !r_q.ack) begin
                    r_d.addr = bus_addr_i;
                    if (take_req) begin
                        r_d.state = ST_WAIT;
                    end else begin
                        r_d.ack   = 1'b1;
                        r_d.err   = 1'b1;
                        r_d.rdata = '0;
                    end
                end
            end
            ST_WAIT: begin
                if (!spi_busy_i) begin
                    r_d.start  = 1'b1;
                    r_d.tx     = frame_tx;
                    r_d.nbytes = frame_nb;
                    r_d.state  = ST_XFER;
                end
            end
            ST_XFER: begin
                if (spi_done_i) begin
                    r_d.ack   = 1'b1;
                    r_d.rdata = rx_word;
                    r_d.state = ST_IDLE;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign bus_ack_o    = r_q.ack;
    assign bus_err_o    = r_q.err;
    assign bus_rdata_o  = r_q.rdata;
    assign spi_start_o  = r_q.start;
    assign spi_txdata_o = r_q.tx;
    assign spi_nbytes_o = r_q.nbytes;

    assert_ack_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack_o |=> !bus_ack_o);
    assert_err_needs_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err_o |-> bus_ack_o);
    assert_err_no_launch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err_o |-> !spi_start_o);
    assert_single_launch_R10: assert property (@(posedge clk) disable iff (!rst_n)
        spi_start_o |=> !spi_start_o);
    assert_frame_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
        spi_start_o |-> (spi_nbytes_o >= 4'd6 && spi_nbytes_o <= 4'd9));
    assert_cmd_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
        spi_start_o |-> spi_txdata_o[XIP_TX_W-1 -: 8] == $past(cfg_rd_cmd_i));
endmodule

// File: tb/tb_xip_fetch_bridge.sv
module tb_xip_fetch_bridge;
    localparam int LAT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_module_en = 1'b0, cfg_xip_en = 1'b0;
    logic [3:0]  cfg_page = 4'h0;
    logic [1:0]  cfg_abytes_m1 = 2'd3;
    logic [7:0]  cfg_rd_cmd = 8'h00;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [31:0] bus_addr = 32'h0;
    logic        bus_ack, bus_err;
    logic [31:0] bus_rdata;
    logic        spi_start;
    logic [3:0]  spi_nbytes;
    logic [63:0] spi_txdata;
    logic        spi_done = 1'b0;
    logic [31:0] spi_rxdata = 32'h0;
    logic        eng_busy = 1'b0, ext_busy = 1'b0;
    logic        spi_busy;
    assign spi_busy = eng_busy | ext_busy;

    int checks = 0, fails = 0, cyc = 0, launches = 0, start_cyc = 0, eng_cnt = 0;
    logic [63:0] last_tx;
    logic [3:0]  last_nb;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    xip_fetch_bridge dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_module_en_i(cfg_module_en), .cfg_xip_en_i(cfg_xip_en),
        .cfg_page_i(cfg_page), .cfg_abytes_m1_i(cfg_abytes_m1), .cfg_rd_cmd_i(cfg_rd_cmd),
        .bus_req_i(bus_req), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
        .bus_ack_o(bus_ack), .bus_err_o(bus_err), .bus_rdata_o(bus_rdata),
        .spi_start_o(spi_start), .spi_nbytes_o(spi_nbytes), .spi_txdata_o(spi_txdata),
        .spi_busy_i(spi_busy), .spi_done_i(spi_done), .spi_rxdata_i(spi_rxdata)
    );

    function automatic logic [31:0] rx_of(input logic [63:0] tx);
        return tx[55:24] ^ 32'h5A3C9617;
    endfunction

    // Behavioural serial engine: busy for LAT cycles, then a done pulse.
    always @(negedge clk) begin
        spi_done <= 1'b0;
        if (spi_start) begin
            launches  <= launches + 1;
            start_cyc <= cyc;
            last_tx   <= spi_txdata;
            last_nb   <= spi_nbytes;
            eng_busy  <= 1'b1;
            eng_cnt   <= LAT;
        end else if (eng_busy) begin
            if (eng_cnt == 1) begin
                eng_busy   <= 1'b0;
                spi_done   <= 1'b1;
                spi_rxdata <= rx_of(last_tx);
            end else begin
                eng_cnt <= eng_cnt - 1;
            end
        end
    end

    // Per-cycle comparison against the bench's idea of legal output.
    always @(negedge clk) if (rst_n) begin
        if (bus_err && !bus_ack) begin
            fails++; $display("FAIL R11 err without ack: act=%0d exp=0", bus_err);
        end
        if (spi_start && spi_busy) begin
            fails++; $display("FAIL R10 launch while busy: act=1 exp=0");
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // Expected frame computed byte by byte from the requirements.
    function automatic logic [63:0] exp_frame(input logic [31:0] a, input int nab, input logic [7:0] cmd);
        logic [63:0] f = '0;
        logic [31:0] low = a & 32'h0FFF_FFFF;
        f[63:56] = cmd;
        for (int i = 0; i < nab; i++) begin
            logic [7:0] b = 8'((low >> (8 * (nab - 1 - i))) & 32'hFF);
            f = f | (64'(b) << (48 - 8 * i));
        end
        return f;
    endfunction

    function automatic logic [31:0] swap(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    task automatic do_read(input logic [31:0] a, input logic w, input int hold,
                           output logic e, output logic [31:0] d, output int lat,
                           output int nl, output int srel, output logic pulse_ok);
        int k = 0;
        int l0;
        int c0;
        @(negedge clk);
        l0 = launches; c0 = cyc;
        if (hold > 0) ext_busy = 1'b1;
        bus_req = 1'b1; bus_we = w; bus_addr = a;
        while (!bus_ack && k < 300) begin
            @(negedge clk); k++;
            if (k == hold) ext_busy = 1'b0;
        end
        if (!bus_ack) begin
            fails++; $display("FAIL watchdog: no acknowledge act=0 exp=1");
        end
        e = bus_err; d = bus_rdata; lat = k;
        bus_req = 1'b0; bus_we = 1'b0;
        @(negedge clk);
        pulse_ok = !bus_ack;
        nl = launches - l0;
        srel = start_cyc - c0;
    endtask

    task automatic hit_case(input logic [31:0] a, input int ab_m1, input int hold);
        logic e, p; logic [31:0] d; int lat, nl, sr, st;
        logic [63:0] ef;
        cfg_abytes_m1 = 2'(ab_m1);
        do_read(a, 1'b0, hold, e, d, lat, nl, sr, p);
        ef = exp_frame(a, ab_m1 + 1, cfg_rd_cmd);
        st = (hold > 0) ? hold + 1 : 2;
        chk(e == 1'b0, "R2 no error on window read", 64'(e), 0);
        chk(nl == 1, "R2 one launch", 64'(nl), 1);
        chk(last_tx[63:56] == cfg_rd_cmd, "R6 opcode first", 64'(last_tx[63:56]), 64'(cfg_rd_cmd));
        chk(last_tx == ef, "R7 address bytes", last_tx, ef);
        chk(last_nb == 4'(ab_m1 + 6), "R8 byte count", 64'(last_nb), 64'(ab_m1 + 6));
        chk(d == swap(rx_of(ef)), "R9 returned word", 64'(d), 64'(swap(rx_of(ef))));
        chk(sr == st, "R10 launch cycle", 64'(sr), 64'(st));
        chk(lat == st + LAT + 1, "R11 ack cycle", 64'(lat), 64'(st + LAT + 1));
        chk(p, "R11 ack pulse", 64'(!p), 0);
    endtask

    task automatic refuse_case(input logic [31:0] a, input logic w, input string req);
        logic e, p; logic [31:0] d; int lat, nl, sr;
        do_read(a, w, 0, e, d, lat, nl, sr, p);
        chk(e == 1'b1, req, 64'(e), 1);
        chk(nl == 0, req, 64'(nl), 0);
        chk(lat == 1, req, 64'(lat), 1);
        chk(d == 32'h0, req, 64'(d), 0);
    endtask

    initial begin
        bit timeout = 0;
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                // R1 reset state
                chk(!bus_ack && !bus_err && !spi_start && bus_rdata == 0, "R1 reset outputs",
                    {bus_ack, bus_err, spi_start, bus_rdata}, 0);
                cfg_module_en = 1'b1; cfg_xip_en = 1'b1; cfg_page = 4'hA; cfg_rd_cmd = 8'h0B;
                hit_case(32'hA123_4568, 3, 0);
                hit_case(32'hAFED_CBA4, 0, 0);
                hit_case(32'hA0B1_C2D0, 1, 0);
                cfg_rd_cmd = 8'h03;
                hit_case(32'hA765_4320, 2, 0);
                hit_case(32'hA000_0FFC, 3, 5);   // R10 busy wait
                refuse_case(32'hB123_4568, 1'b0, "R4 window miss");
                refuse_case(32'hA123_4568, 1'b1, "R5 write in window");
                cfg_xip_en = 1'b0;
                refuse_case(32'hA123_4568, 1'b0, "R3 translation off");
                cfg_xip_en = 1'b1; cfg_module_en = 1'b0;
                refuse_case(32'hA123_4568, 1'b0, "R3 module off");
                cfg_module_en = 1'b1; cfg_page = 4'h0;
                hit_case(32'h0ABC_DEF0, 3, 0);
                refuse_case(32'hA123_4568, 1'b0, "R4 old page now misses");
            end
            begin
                repeat (100000) @(posedge clk);
                timeout = 1;
            end
        join_any
        disable fork;
        if (timeout) begin
            checks++; fails++;
            $display("FAIL watchdog expired act=1 exp=0");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule